// File: doc/BRIEF.md
# Atomic Store Permission Checker

This block rules on whether a conditional atomic store may go ahead once the address translation for it has finished. Each lookup presents the translation status, the page's read and write rights, its cache-attribute class, the data-cache-present configuration bit and a 6-bit atomic-control word. One cycle later the block reports either a pass or a fault with a single cause code. It also reports the virtual address of the lookup.

The checks run in a fixed order. A nonzero translation status comes first. A page that is not both readable and writable comes next. The cache-attribute policy comes last. The atomic-control word holds three 2-bit policy fields, one for each cacheable class. A zero field means atomics are not allowed for that class. The cause codes are parameters, so they can be set to match the surrounding core's exception numbering.

Top module: `atomic_store_gate`

## Requirements
- R1: After reset, resultValid, resultFault and resultCause are all 0.
- R2: resultValid is high for exactly the one cycle after each cycle in which lookupValid is high, and is low otherwise. In that cycle resultVaddr equals the vaddrIn that was presented with the lookup.
- R3: A nonzero xlateStatus gives resultFault=1 with resultCause equal to that status, whatever the other inputs are.
- R4: With xlateStatus zero and the page not both readable and writable (pageRead and pageWrite not both 1), the result is a fault with cause STORE_PROHIB_CAUSE (default 29). This applies to read-only and write-only pages alike.
- R5: cacheAttr is encoded as 0 bypass, 1 write-through, 2 write-back, 3 isolate, and 4 to 7 other. When dcachePresent is 0 the attribute is taken as bypass, whatever cacheAttr says.
- R6: For the bypass, write-through and write-back classes, the policy field is atomCtrl[1:0], atomCtrl[3:2] and atomCtrl[5:4] respectively. A zero field gives a fault with cause LS_ERROR_CAUSE (default 3), and a nonzero field gives a pass.
- R7: The isolate class always faults with LS_ERROR_CAUSE. The other classes always pass, whatever atomCtrl holds. A pass reports resultFault=0 and resultCause=0.
- R8: A translation or permission fault takes precedence over the attribute check, and only one cause is reported per lookup.
- R9: In cycles without a result, resultFault, resultCause and resultVaddr keep the values of the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Strobe that starts a check |
| xlateStatus | input | CAUSE_W | Translation status, 0 means success |
| pageRead | input | 1 | Page is readable |
| pageWrite | input | 1 | Page is writable |
| cacheAttr | input | 3 | Cache-attribute class |
| dcachePresent | input | 1 | Data cache is configured |
| atomCtrl | input | 6 | Atomic-control policy word |
| vaddrIn | input | ADDR_W | Virtual address of the access |
| resultValid | output | 1 | Result strobe, one cycle after the lookup |
| resultFault | output | 1 | Access must fault |
| resultCause | output | CAUSE_W | Fault cause, 0 on pass |
| resultVaddr | output | ADDR_W | Virtual address of the result |

## Verification
The bench drives one directed lookup per scenario and samples the outputs in the single cycle in which resultValid is high. A wrong decision shows up as a wrong fault bit or cause in that same cycle. A wrong field selection or a wrong precedence only shows when the scenario pairs a zero field, or a fault, with a class whose field is nonzero. For that reason the cases use asymmetric control words. A result that fails to hold shows up one cycle later, in the idle cycle that follows each lookup.

// File: rtl/atomic_store_gate_pkg.sv
package atomic_store_gate_pkg;

  typedef enum logic [2:0] {
    ATTR_BYPASS  = 3'd0,
    ATTR_WTHRU   = 3'd1,
    ATTR_WBACK   = 3'd2,
    ATTR_ISOLATE = 3'd3
  } cacheAttr_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_XLATE = 2'd1,
    SEL_STORE = 2'd2,
    SEL_LSERR = 2'd3
  } causeSel_e;

  typedef struct packed {
    logic      load;
    logic      fault;
    causeSel_e causeSel;
  } gateStrobe_t;

endpackage

// File: rtl/atomic_store_gate_ctrl.sv
module atomic_store_gate_ctrl
  import atomic_store_gate_pkg::*;
#(
  parameter int CAUSE_W = 6,
  parameter int CTRL_W  = 6
) (
  input  logic               lookupValid,
  input  logic [CAUSE_W-1:0] xlateStatus,
  input  logic               pageRead,
  input  logic               pageWrite,
  input  logic [2:0]         cacheAttr,
  input  logic               dcachePresent,
  input  logic [CTRL_W-1:0]  atomCtrl,
  output gateStrobe_t        strb
);
  localparam int FIELD_W  = 2;
  localparam int N_FIELDS = CTRL_W / FIELD_W;

  logic [2:0]         attrEff;
  logic [N_FIELDS-1:0] fieldZero;
  logic               policyClass;
  logic               selZero;

  // one zero detector per policy field
  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    assign fieldZero[g] = (atomCtrl[g*FIELD_W +: FIELD_W] == '0);
  end

  always_comb begin
    attrEff     = dcachePresent ? cacheAttr : 3'(ATTR_BYPASS);
    policyClass = (attrEff == 3'(ATTR_BYPASS)) || (attrEff == 3'(ATTR_WTHRU)) ||
                  (attrEff == 3'(ATTR_WBACK));
    selZero     = 1'b0;
    if (policyClass && (int'(attrEff) < N_FIELDS)) selZero = fieldZero[attrEff[1:0]];
  end

  always_comb begin
    strb.load     = lookupValid;
    strb.fault    = 1'b1;
    strb.causeSel = SEL_NONE;
    if (xlateStatus != '0)                  strb.causeSel = SEL_XLATE;
    else if (!(pageRead && pageWrite))      strb.causeSel = SEL_STORE;
    else if (attrEff == 3'(ATTR_ISOLATE))   strb.causeSel = SEL_LSERR;
    else if (policyClass && selZero)        strb.causeSel = SEL_LSERR;
    else                                    strb.fault    = 1'b0;
  end

endmodule

// File: rtl/atomic_store_gate_dp.sv
module atomic_store_gate_dp
  import atomic_store_gate_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          CAUSE_W = 6,
  parameter logic [CAUSE_W-1:0] STORE_PROHIB_CAUSE = 29,
  parameter logic [CAUSE_W-1:0] LS_ERROR_CAUSE     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  gateStrobe_t        strb,
  input  logic [CAUSE_W-1:0] xlateStatus,
  input  logic [ADDR_W-1:0]  vaddrIn,
  output logic               resultValid,
  output logic               resultFault,
  output logic [CAUSE_W-1:0] resultCause,
  output logic [ADDR_W-1:0]  resultVaddr
);
  logic [CAUSE_W-1:0] causeNext;

  always_comb begin
    unique case (strb.causeSel)
      SEL_XLATE: causeNext = xlateStatus;
      SEL_STORE: causeNext = STORE_PROHIB_CAUSE;
      SEL_LSERR: causeNext = LS_ERROR_CAUSE;
      default:   causeNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      resultFault <= 1'b0;
      resultCause <= '0;
      resultVaddr <= '0;
    end else begin
      resultValid <= strb.load;
      if (strb.load) begin
        resultFault <= strb.fault;
        resultCause <= causeNext;
        resultVaddr <= vaddrIn;
      end
    end
  end

  // R2: result strobe tracks the lookup strobe by one cycle
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> resultValid);
  p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> !resultValid);
  // R9: idle cycles leave the result untouched
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(resultFault) && $stable(resultCause) && $stable(resultVaddr)));

endmodule

// File: rtl/atomic_store_gate.sv
module atomic_store_gate
  import atomic_store_gate_pkg::*;
#(
  parameter int          ADDR_W  = 32,
  parameter int          CAUSE_W = 6,
  parameter logic [CAUSE_W-1:0] STORE_PROHIB_CAUSE = 29,
  parameter logic [CAUSE_W-1:0] LS_ERROR_CAUSE     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [CAUSE_W-1:0] xlateStatus,
  input  logic               pageRead,
  input  logic               pageWrite,
  input  logic [2:0]         cacheAttr,
  input  logic               dcachePresent,
  input  logic [5:0]         atomCtrl,
  input  logic [ADDR_W-1:0]  vaddrIn,
  output logic               resultValid,
  output logic               resultFault,
  output logic [CAUSE_W-1:0] resultCause,
  output logic [ADDR_W-1:0]  resultVaddr
);
  gateStrobe_t strb;

  atomic_store_gate_ctrl #(.CAUSE_W(CAUSE_W), .CTRL_W(6)) i_ctrl (
    .lookupValid(lookupValid), .xlateStatus(xlateStatus),
    .pageRead(pageRead), .pageWrite(pageWrite), .cacheAttr(cacheAttr),
    .dcachePresent(dcachePresent), .atomCtrl(atomCtrl), .strb(strb));

  atomic_store_gate_dp #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W),
    .STORE_PROHIB_CAUSE(STORE_PROHIB_CAUSE), .LS_ERROR_CAUSE(LS_ERROR_CAUSE)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .xlateStatus(xlateStatus),
    .vaddrIn(vaddrIn), .resultValid(resultValid), .resultFault(resultFault),
    .resultCause(resultCause), .resultVaddr(resultVaddr));

  // R3: translation status is reported unchanged
  p_xlate_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && xlateStatus != '0) |=> (resultFault && resultCause == $past(xlateStatus)));
  // R4 / R8: permission fault wins over attribute policy
  p_perm_first_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && xlateStatus == '0 && !(pageRead && pageWrite))
      |=> (resultFault && resultCause == STORE_PROHIB_CAUSE));
  // R7: isolate with a usable page always faults with load/store error
  p_isolate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && xlateStatus == '0 && pageRead && pageWrite && dcachePresent &&
     cacheAttr == 3'(ATTR_ISOLATE)) |=> (resultFault && resultCause == LS_ERROR_CAUSE));
  // R7: a pass carries no cause
  p_pass_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !resultFault) |-> (resultCause == '0));

endmodule

// File: tb/test_atomic_store_gate.sv
module test_atomic_store_gate;
  localparam int AW = 32;
  localparam int CW = 6;
  localparam logic [CW-1:0] SP = 29;
  localparam logic [CW-1:0] LE = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [CW-1:0] xlateStatus = '0;
  logic pageRead = 1'b0, pageWrite = 1'b0;
  logic [2:0] cacheAttr = '0;
  logic dcachePresent = 1'b1;
  logic [5:0] atomCtrl = '0;
  logic [AW-1:0] vaddrIn = '0;
  logic resultValid, resultFault;
  logic [CW-1:0] resultCause;
  logic [AW-1:0] resultVaddr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  atomic_store_gate #(.ADDR_W(AW), .CAUSE_W(CW), .STORE_PROHIB_CAUSE(SP),
    .LS_ERROR_CAUSE(LE)) i_atomic_store_gate (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .xlateStatus(xlateStatus),
    .pageRead(pageRead), .pageWrite(pageWrite), .cacheAttr(cacheAttr),
    .dcachePresent(dcachePresent), .atomCtrl(atomCtrl), .vaddrIn(vaddrIn),
    .resultValid(resultValid), .resultFault(resultFault),
    .resultCause(resultCause), .resultVaddr(resultVaddr));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one lookup, then a check in the result cycle and in the idle cycle after it
  task automatic lookup(input string tag, input logic [CW-1:0] st, input logic rd,
                        input logic wr, input logic [2:0] attr, input logic dc,
                        input logic [5:0] ctl, input logic [AW-1:0] va,
                        input logic expFault, input logic [CW-1:0] expCause);
    @(negedge clk);
    xlateStatus = st; pageRead = rd; pageWrite = wr; cacheAttr = attr;
    dcachePresent = dc; atomCtrl = ctl; vaddrIn = va; lookupValid = 1'b1;
    @(negedge clk);
    lookupValid = 1'b0;
    xlateStatus = 6'h3f; pageRead = 1'b0; vaddrIn = ~va;
    check({tag, " R2 valid"}, 64'(resultValid), 64'(1));
    check({tag, " R2 vaddr"}, 64'(resultVaddr), 64'(va));
    check({tag, " fault"}, 64'(resultFault), 64'(expFault));
    check({tag, " cause"}, 64'(resultCause), 64'(expCause));
    @(negedge clk);
    check({tag, " R2 pulse"}, 64'(resultValid), 64'(0));
    check({tag, " R9 hold fault"}, 64'(resultFault), 64'(expFault));
    check({tag, " R9 hold cause"}, 64'(resultCause), 64'(expCause));
    check({tag, " R9 hold vaddr"}, 64'(resultVaddr), 64'(va));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 valid", 64'(resultValid), 64'(0));
    check("R1 fault", 64'(resultFault), 64'(0));
    check("R1 cause", 64'(resultCause), 64'(0));
    rstN = 1'b1;
  endtask

  task automatic t_xlate();
    lookup("R3 status5 isolate", 6'd5, 1, 1, 3'd3, 1, 6'h3f, 32'h1000_0004, 1, 6'd5);
    lookup("R3 status2 no perm", 6'd2, 0, 0, 3'd0, 1, 6'h00, 32'h2000_0008, 1, 6'd2);
  endtask

  task automatic t_perm();
    lookup("R4 read only", 6'd0, 1, 0, 3'd0, 1, 6'h3f, 32'h3000_0010, 1, SP);
    lookup("R4 write only", 6'd0, 0, 1, 3'd2, 1, 6'h3f, 32'h3000_0020, 1, SP);
    lookup("R8 perm over isolate", 6'd0, 0, 1, 3'd3, 1, 6'h00, 32'h3000_0030, 1, SP);
  endtask

  task automatic t_fields();
    lookup("R6 bypass zero", 6'd0, 1, 1, 3'd0, 1, 6'b111100, 32'h4000_0000, 1, LE);
    lookup("R6 bypass set", 6'd0, 1, 1, 3'd0, 1, 6'b000010, 32'h4000_0040, 0, 6'd0);
    lookup("R6 wthru zero", 6'd0, 1, 1, 3'd1, 1, 6'b110011, 32'h4000_0080, 1, LE);
    lookup("R6 wthru set", 6'd0, 1, 1, 3'd1, 1, 6'b000100, 32'h4000_00c0, 0, 6'd0);
    lookup("R6 wback zero", 6'd0, 1, 1, 3'd2, 1, 6'b001111, 32'h4000_0100, 1, LE);
    lookup("R6 wback set", 6'd0, 1, 1, 3'd2, 1, 6'b100000, 32'h4000_0140, 0, 6'd0);
  endtask

  task automatic t_nocache();
    lookup("R5 no cache wback->bypass zero", 6'd0, 1, 1, 3'd2, 0, 6'b110000, 32'h5000_0000, 1, LE);
    lookup("R5 no cache isolate->bypass set", 6'd0, 1, 1, 3'd3, 0, 6'b000001, 32'h5000_0004, 0, 6'd0);
  endtask

  task automatic t_special();
    lookup("R7 isolate all ones", 6'd0, 1, 1, 3'd3, 1, 6'h3f, 32'h6000_0000, 1, LE);
    lookup("R7 other ctrl zero", 6'd0, 1, 1, 3'd5, 1, 6'h00, 32'h6000_0008, 0, 6'd0);
    lookup("R7 other attr7", 6'd0, 1, 1, 3'd7, 1, 6'h00, 32'h6000_000c, 0, 6'd0);
  endtask

  task automatic t_backtoback();
    @(negedge clk);
    xlateStatus = 0; pageRead = 1; pageWrite = 1; dcachePresent = 1;
    cacheAttr = 3'd3; atomCtrl = 6'h3f; vaddrIn = 32'hA; lookupValid = 1;
    @(negedge clk);
    check("R2 b2b first valid", 64'(resultValid), 64'(1));
    check("R7 b2b first cause", 64'(resultCause), 64'(LE));
    cacheAttr = 3'd0; vaddrIn = 32'hB;
    @(negedge clk);
    lookupValid = 0;
    check("R2 b2b second valid", 64'(resultValid), 64'(1));
    check("R2 b2b second vaddr", 64'(resultVaddr), 64'(32'hB));
    check("R6 b2b second fault", 64'(resultFault), 64'(0));
    @(negedge clk);
    check("R2 b2b end", 64'(resultValid), 64'(0));
  endtask

  initial begin
    t_reset();
    t_xlate();
    t_perm();
    t_fields();
    t_nocache();
    t_special();
    t_backtoback();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule